// File: doc/BRIEF.md
# LIN header auto-baud detector

This block sits beside a 16x-oversampling UART receiver and watches the serial input for the header of a LIN frame. While enabled, it first looks for a break. A break is a low stretch on the line that lasts longer than eleven bit times at the baud rate programmed now. After the break, the block times the 0x55 sync byte in clock cycles, from its first falling edge to its fifth.

From that count the block computes a new integer and fractional baud divisor and loads both into its divisor registers. In the same cycle it resets the receive FIFO pointers, so that the next byte, the protected identifier, lands in FIFO entry zero. When the UART delivers that identifier byte, the block checks its two parity bits and flags a mismatch.

The divisor registers drive the receiver's baud generator. A bit time in clock cycles is T = 16*div_int + div_frac, so div_frac counts sixteenths of the integer divisor. If the sync byte never completes before the cycle counter is full, the block raises a timeout and goes back to looking for a break. In that case the divisors keep their values.

Top module: `lin_autobaud`

## Requirements
- R1: While en_i is low, no flag pulses, the divisors hold their values and the detector returns to waiting for a break. A sync pattern that was already partly counted is abandoned.
- R2: With T = 16*div_int_o + div_frac_o, brk_o pulses for one cycle after the (11*T+1)-th consecutive low sample of rxd_i while the block waits for a break. A low run of exactly 11*T samples gives no pulse.
- R3: After a break, the line must first be seen high. The next falling edge starts the measurement, and the fifth falling edge ends it. N is the number of clock cycles from the sample of the first edge to the sample of the fifth edge.
- R4: On the fifth edge, v = floor((N+4)/8). v is saturated to all ones of INT_W+4 bits, where INT_W = CNT_W-7. Then div_int_o = v>>4 and div_frac_o = v[3:0]. Both load in the cycle after the fifth edge is sampled.
- R5: Rounding uses count bit 2. A round-up from a fraction of 15 clears the fraction and increments the integer divisor (N=508 gives integer 4, fraction 0).
- R6: The divisor outputs change only in a cycle in which sync_o is high.
- R7: sync_o and fifo_rst_o pulse together for one cycle, in the cycle after the fifth falling edge is sampled.
- R8: The first byte with rx_valid_i high after sync is the identifier: ID in bits 5:0, P0 in bit 6, P1 in bit 7. The expected values are P0 = ID0^ID1^ID2^ID4 and P1 = ~(ID1^ID3^ID4^ID5). pid_err_o pulses in the next cycle if either bit differs, and the block then waits for a break again.
- R9: A byte that arrives outside the identifier window never produces pid_err_o.
- R10: If the cycle count reaches 2^CNT_W-1 in a cycle with no fifth edge, tmo_o pulses in the next cycle. The divisors do not change, and the block waits for a break again.
- R11: After reset, all flags are low and the divisors hold their reset parameter values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Header detection enable |
| rxd_i | input | 1 | Serial line, synchronous to clk_i |
| rx_valid_i | input | 1 | UART receiver has a byte |
| rx_byte_i | input | 8 | Received byte |
| brk_o | output | 1 | Break detected pulse |
| sync_o | output | 1 | Sync measured pulse |
| fifo_rst_o | output | 1 | Receive FIFO pointer reset pulse |
| pid_err_o | output | 1 | Identifier parity error pulse |
| tmo_o | output | 1 | Sync timeout pulse |
| div_int_o | output | CNT_W-7 | Integer baud divisor |
| div_frac_o | output | 4 | Fractional baud divisor, sixteenths |

## Verification
A wrong break-run count shows up as a brk_o pulse that is one cycle early or late, or that is missing at the 11*T boundary. It also shifts every later flag. A wrong edge or cycle count shows up in the divisor values and in the timing of sync_o one cycle after the fifth edge. A stuck state shows up as a missing timeout after 2^CNT_W-1 cycles, or as parity being judged on a byte outside the identifier window. The reference model is compared with every output on every cycle, so any of these faults is reported in the cycle where the outputs first differ.

// File: rtl/lin_ab_pkg.sv
package lin_ab_pkg;
  localparam int FRAC_W   = 4;  // 16x oversampling -> sixteenths
  localparam int BITS_LOG = 3;  // span covers 8 bit times
  localparam int BRK_BITS = 11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BRK,
    ST_WAIT1,
    ST_COUNT,
    ST_PID
  } ab_state_e;
endpackage

// File: rtl/lin_ab_brk.sv
module lin_ab_brk #(
  parameter int INT_W = 16,
  parameter int LOW_W = 24
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          run_i,
  input  logic                          rxd_i,
  input  logic [INT_W-1:0]              div_int_i,
  input  logic [lin_ab_pkg::FRAC_W-1:0] div_frac_i,
  output logic                          hit_o
);
  import lin_ab_pkg::*;
  localparam int BT_W = INT_W + FRAC_W;

  logic [LOW_W-1:0] low_q, lim;

  assign lim   = LOW_W'({div_int_i, div_frac_i}) * LOW_W'(BRK_BITS);
  assign hit_o = run_i && !rxd_i && (low_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 low_q <= '0;
    else if (!run_i || rxd_i)    low_q <= '0;
    else if (low_q != '1)        low_q <= low_q + 1'b1;
  end
endmodule

// File: rtl/lin_ab_sync.sv
module lin_ab_sync #(
  parameter int CNT_W = 23
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             run_i,
  input  logic             fall_i,
  output logic             done_o,
  output logic             tmo_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       edg_q;

  assign cnt_o  = cnt_q;
  assign done_o = run_i && fall_i && (edg_q == 3'd4);
  assign tmo_o  = run_i && !fall_i && (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      edg_q <= '0;
    end else if (arm_i && fall_i) begin
      cnt_q <= CNT_W'(1);  // counts the cycle of each later edge inclusively
      edg_q <= 3'd1;
    end else if (run_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (fall_i) edg_q <= edg_q + 3'd1;
    end
  end
endmodule

// File: rtl/lin_ab_div.sv
module lin_ab_div #(
  parameter int CNT_W    = 23,
  parameter int INT_W    = 16,
  parameter int INT_RST  = 4,
  parameter int FRAC_RST = 0
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic [CNT_W-1:0]              cnt_i,
  output logic [INT_W-1:0]              div_int_o,
  output logic [lin_ab_pkg::FRAC_W-1:0] div_frac_o
);
  import lin_ab_pkg::*;
  localparam int V_W = INT_W + FRAC_W;

  logic [V_W:0]   sum;
  logic [V_W-1:0] val;

  assign sum = {1'b0, cnt_i[CNT_W-1:BITS_LOG]} + (V_W+1)'(cnt_i[BITS_LOG-1]);
  assign val = sum[V_W] ? '1 : sum[V_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_int_o  <= INT_W'(INT_RST);
      div_frac_o <= FRAC_W'(FRAC_RST);
    end else if (load_i) begin
      div_int_o  <= val[V_W-1:FRAC_W];
      div_frac_o <= val[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/lin_ab_pid.sv
module lin_ab_pid (
  input  logic [7:0] byte_i,
  output logic       bad_o
);
  logic p0, p1;
  assign p0    = byte_i[0] ^ byte_i[1] ^ byte_i[2] ^ byte_i[4];
  assign p1    = ~(byte_i[1] ^ byte_i[3] ^ byte_i[4] ^ byte_i[5]);
  assign bad_o = (p0 != byte_i[6]) || (p1 != byte_i[7]);
endmodule

// File: rtl/lin_autobaud.sv
module lin_autobaud #(
  parameter int CNT_W    = 23,
  parameter int INT_RST  = 4,
  parameter int FRAC_RST = 0,
  localparam int INT_W   = CNT_W - 7,
  localparam int LOW_W   = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rxd_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_byte_i,
  output logic             brk_o,
  output logic             sync_o,
  output logic             fifo_rst_o,
  output logic             pid_err_o,
  output logic             tmo_o,
  output logic [INT_W-1:0] div_int_o,
  output logic [3:0]       div_frac_o
);
  import lin_ab_pkg::*;

  ab_state_e        st_q, st_d;
  logic             rxd_q, fall;
  logic             brk_hit, done, tmo, pid_bad;
  logic [CNT_W-1:0] cnt;

  assign fall = rxd_q && !rxd_i;

  lin_ab_brk #(.INT_W(INT_W), .LOW_W(LOW_W)) u_brk (
    .clk_i, .rst_ni,
    .run_i     (en_i && st_q == ST_IDLE),
    .rxd_i,
    .div_int_i (div_int_o),
    .div_frac_i(div_frac_o),
    .hit_o     (brk_hit)
  );

  lin_ab_sync #(.CNT_W(CNT_W)) u_sync (
    .clk_i, .rst_ni,
    .arm_i (en_i && st_q == ST_WAIT1),
    .run_i (en_i && st_q == ST_COUNT),
    .fall_i(fall),
    .done_o(done),
    .tmo_o (tmo),
    .cnt_o (cnt)
  );

  lin_ab_div #(.CNT_W(CNT_W), .INT_W(INT_W), .INT_RST(INT_RST), .FRAC_RST(FRAC_RST)) u_div (
    .clk_i, .rst_ni,
    .load_i    (done),
    .cnt_i     (cnt),
    .div_int_o,
    .div_frac_o
  );

  lin_ab_pid u_pid (.byte_i(rx_byte_i), .bad_o(pid_bad));

  always_comb begin
    st_d = st_q;
    if (!en_i) st_d = ST_IDLE;
    else begin
      unique case (st_q)
        ST_IDLE:  if (brk_hit) st_d = ST_BRK;
        ST_BRK:   if (rxd_i) st_d = ST_WAIT1;
        ST_WAIT1: if (fall) st_d = ST_COUNT;
        ST_COUNT: if (done) st_d = ST_PID;
                  else if (tmo) st_d = ST_IDLE;
        ST_PID:   if (rx_valid_i) st_d = ST_IDLE;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      rxd_q      <= 1'b1;
      brk_o      <= 1'b0;
      sync_o     <= 1'b0;
      fifo_rst_o <= 1'b0;
      pid_err_o  <= 1'b0;
      tmo_o      <= 1'b0;
    end else begin
      st_q       <= st_d;
      rxd_q      <= rxd_i;
      brk_o      <= brk_hit;
      sync_o     <= done;
      fifo_rst_o <= done;
      pid_err_o  <= en_i && st_q == ST_PID && rx_valid_i && pid_bad;
      tmo_o      <= tmo;
    end
  end
endmodule

// File: rtl/lin_autobaud_chk.sv
module lin_autobaud_chk #(
  parameter int INT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             rxd_i,
  input logic             rx_valid_i,
  input logic             brk_o,
  input logic             sync_o,
  input logic             fifo_rst_o,
  input logic             pid_err_o,
  input logic             tmo_o,
  input logic [INT_W-1:0] div_int_o,
  input logic [3:0]       div_frac_o
);
  AST_DIV_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(div_int_o) && $stable(div_frac_o)); // R1
  AST_FLAGS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !brk_o && !sync_o && !pid_err_o && !tmo_o); // R1
  AST_BRK_ON_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> $past(!rxd_i)); // R2
  AST_DIV_ONLY_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(($stable(div_int_o)) && ($stable(div_frac_o))) |-> sync_o); // R6
  AST_FIFO_WITH_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> fifo_rst_o); // R7
  AST_SYNC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o); // R7
  AST_PERR_NEEDS_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pid_err_o |-> $past(rx_valid_i)); // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({brk_o, sync_o, pid_err_o, tmo_o})); // R10
endmodule

bind lin_autobaud lin_autobaud_chk #(.INT_W(INT_W)) u_chk (.*);

// File: tb/tb_lin_autobaud.sv
module tb_lin_autobaud;
  localparam int CNT_W = 12;
  localparam int INT_W = CNT_W - 7;
  localparam int MAXC  = (1 << CNT_W) - 1;
  localparam int VMAX  = (1 << (INT_W + 4)) - 1;

  logic clk = 0, rst_n = 0, en = 0, rxd = 1, rxv = 0;
  logic [7:0] rxb = 0;
  logic brk, sync, frst, perr, tmo;
  logic [INT_W-1:0] dint;
  logic [3:0] dfrac;
  int total = 0, bad = 0;
  int n_brk = 0, n_sync = 0, n_perr = 0, n_tmo = 0;

  always #5 clk = ~clk;

  lin_autobaud #(.CNT_W(CNT_W), .INT_RST(4), .FRAC_RST(0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .rxd_i(rxd), .rx_valid_i(rxv),
    .rx_byte_i(rxb), .brk_o(brk), .sync_o(sync), .fifo_rst_o(frst),
    .pid_err_o(perr), .tmo_o(tmo), .div_int_o(dint), .div_frac_o(dfrac));

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit pid_ok(logic [7:0] b);
    bit p0 = b[0] ^ b[1] ^ b[2] ^ b[4];
    bit p1 = !(b[1] ^ b[3] ^ b[4] ^ b[5]);
    return (b[6] == p0) && (b[7] == p1);
  endfunction

  // behavioural reference model
  int m_st, m_low, m_n, m_e, m_di, m_df, v;
  bit m_rp, m_brk, m_sync, m_perr, m_tmo, fall;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_low = 0; m_n = 0; m_e = 0; m_di = 4; m_df = 0; m_rp = 1;
      m_brk = 0; m_sync = 0; m_perr = 0; m_tmo = 0;
    end else begin
      m_brk = 0; m_sync = 0; m_perr = 0; m_tmo = 0;
      fall = m_rp && !rxd;
      if (!en) begin m_st = 0; m_low = 0; end
      else case (m_st)
        0: if (!rxd) begin
             if (m_low == 11 * (16 * m_di + m_df)) begin m_brk = 1; m_st = 1; m_low = 0; end
             else m_low++;
           end else m_low = 0;
        1: if (rxd) m_st = 2;
        2: if (fall) begin m_n = 1; m_e = 1; m_st = 3; end
        3: if (fall && m_e == 4) begin
             v = (m_n + 4) / 8;
             if (v > VMAX) v = VMAX;
             m_di = v / 16; m_df = v % 16; m_sync = 1; m_st = 4;
           end else if (!fall && m_n == MAXC) begin m_tmo = 1; m_st = 0; end
           else begin m_n++; if (fall) m_e++; end
        4: if (rxv) begin m_perr = !pid_ok(rxb); m_st = 0; end
        default: m_st = 0;
      endcase
      m_rp = rxd;
    end
  end

  always @(negedge clk) begin
    chk("R2 brk_o", brk, m_brk);
    chk("R7 sync_o", sync, m_sync);
    chk("R7 fifo_rst_o", frst, m_sync);
    chk("R8 pid_err_o", perr, m_perr);
    chk("R10 tmo_o", tmo, m_tmo);
    chk("R4 div_int_o", dint, m_di);
    chk("R4 div_frac_o", dfrac, m_df);
    n_brk += brk; n_sync += sync; n_perr += perr; n_tmo += tmo;
  end

  task automatic hold(bit lvl, int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; rxd = lvl; end
  endtask

  task automatic send_sync(int n);
    for (int i = 0; i < (10 * n) / 8 + 4; i++) begin
      int k = (i * 8) / n;
      @(posedge clk); #2;
      rxd = (k == 0) ? 1'b0 : (k >= 9) ? 1'b1 : bit'((8'h55 >> (k - 1)) & 1);
    end
  endtask

  task automatic send_byte(logic [7:0] b);
    @(posedge clk); #2; rxv = 1; rxb = b;
    @(posedge clk); #2; rxv = 0;
    hold(1, 4);
  endtask

  task automatic frame(int n, logic [7:0] pid);
    hold(0, 800); hold(1, 20); send_sync(n); send_byte(pid);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R11 div_int reset", dint, 4);
    chk("R11 div_frac reset", dfrac, 0);
    chk("R11 flags reset", {brk, sync, frst, perr, tmo}, 0);
    rst_n = 1; en = 1;
    hold(1, 5);
    // R2 boundary: 11*T = 704 lows, no break; 705 lows, break
    hold(0, 704); hold(1, 5);
    chk("R2 no break at 11T", n_brk, 0);
    hold(0, 705); hold(1, 5);
    chk("R2 break after 11T", n_brk, 1);
    en = 0; hold(1, 2); en = 1;
    // R1: disabled, long low ignored
    en = 0; hold(0, 800); hold(1, 5); en = 1; hold(1, 2);
    chk("R1 no break when off", n_brk, 1);
    // R3/R4 frame
    frame(403, 8'h3C);
    chk("R3 sync count", n_sync, 1);
    chk("R4 int N=403", dint, 3);
    chk("R4 frac N=403", dfrac, 2);
    chk("R8 good pid", n_perr, 0);
    frame(500, 8'h7C);
    chk("R4 int N=500", dint, 3);
    chk("R4 frac N=500", dfrac, 15);
    chk("R8 bad pid flagged", n_perr, 1);
    frame(508, 8'h3C);
    chk("R5 carry int", dint, 4);
    chk("R5 carry frac", dfrac, 0);
    // R9: stray byte outside window
    send_byte(8'h7C);
    chk("R9 stray byte ignored", n_perr, 1);
    // R10 timeout
    hold(0, 800); hold(1, 20); hold(0, 10); hold(1, MAXC + 100);
    chk("R10 timeout seen", n_tmo, 1);
    chk("R10 div_int kept", dint, 4);
    chk("R10 div_frac kept", dfrac, 0);
    // R1 disable mid measurement
    hold(0, 800); hold(1, 20); hold(0, 10); hold(1, 30);
    en = 0; hold(1, 2); en = 1;
    send_sync(403); hold(1, 10);
    chk("R1 sync abandoned", n_sync, 3);
    chk("R1 div kept", dint, 4);
    // R4 saturation
    frame(MAXC, 8'h3C);
    chk("R4 sat int", dint, 31);
    chk("R4 sat frac", dfrac, 15);
    chk("R7 total syncs", n_sync, 4);
    hold(1, 5);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule